// File: doc/BRIEF.md
# Gated Multi-Output Clock-Enable Generator

This block turns one reference clock into a set of per-output clock enables, each with its own divide ratio and starting phase, plus a small set of reset outputs that release after a programmed number of ticks of a chosen output. Every output is frozen unless a run is in progress: a run request carries a cycle budget N, and the block then lets exactly N reference cycles through to all the dividers. The cycle budget is spent only while the global enable input is high. If that input drops during a run, the gate pauses and the run stretches out.

When the budget is spent, the block raises a one-cycle completion pulse. It also reports how many reference cycles the run took from acceptance to completion, pauses included. Software adds these figures to keep its own notion of time in step with the hardware. Dividers and reset lanes are set up through a write-only register port. Every divider re-aligns to its programmed phase at the start of each run.

Top module: `gated_clkgen`

## Requirements
- R1: After reset all enables are low, the run is idle, no completion pulse is present, the reported count is zero, and all four reset outputs are high. Each reset lane defaults to source output 0 with a hold of 4 ticks.
- R2: No output enable is ever high while no run is in progress, or while the global enable input is low.
- R3: An accepted run with budget N opens the gate for exactly N cycles during which the global enable is high. An output programmed with ratio 1 and phase 0 therefore ticks exactly N times.
- R4: Writing address i (0..15) sets output i. Bits [6:0] hold ratio−1, giving a ratio of 1 to 128, and bits [14:8] hold the phase. Counting open cycles of a run from 0, output i ticks at indices p, p+R, p+2R, and so on.
- R5: A phase written larger than ratio−1 is stored as ratio−1.
- R6: A new ratio written during a run takes effect only when the output next wraps after a tick. The period already in progress completes with the old ratio.
- R7: While the global enable is low during a run, the gate holds and the budget is not spent. The reported count equals N plus the number of such paused cycles.
- R8: The completion pulse is one cycle wide and comes one cycle after the gate closes. At that point the busy output is low and the count is updated. A budget of 0 completes with a count of 0 and no ticks.
- R9: A run request is ignored while a run is in progress or while the global enable is low.
- R10: Writing address 16+j sets reset lane j. Bits [3:0] select the source output and bits [11:4] set the hold length L. The write asserts reset j, which is released at the clock edge that ends the L-th tick of the source. L = 0 deasserts it at once.
- R11: Every accepted run reloads every divider with its phase, so each run starts aligned no matter how earlier runs ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| genEnable | input | 1 | Global enable; low pauses a run and blocks new requests |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Configuration register address |
| cfgData | input | 16 | Configuration write data |
| runValid | input | 1 | Run request |
| runCount | input | 32 | Cycle budget N carried with the request |
| runBusy | output | 1 | A run is in progress |
| runDone | output | 1 | One-cycle completion pulse |
| cyclesUsed | output | 32 | Reference cycles taken by the last run |
| clkEn | output | 16 | Per-output clock enables |
| rstOut | output | 4 | Active-high reset outputs |

## Verification
The checker assumes that a run request is a plain level sampled on each clock edge, and that the global enable may toggle at any cycle, including in the middle of a run. It makes no assumption about when configuration writes arrive, since a write can never open the gate. The stimulus drives every input shortly after the rising edge. It draws random ratios, phases, budgets, reset lanes and pause patterns from a seeded generator, and always keeps a ratio-1, phase-0 output as a reference count of open cycles. Directed cases cover a zero budget, an out-of-range phase, a ratio change in the middle of a run, and requests that arrive while busy or while disabled.

// File: rtl/gclk_pkg.sv
package gclk_pkg;

  // Strobes from the run controller to the divider datapath.
  typedef struct packed {
    logic gateOpen;   // reference cycle passed through to the dividers
    logic syncLoad;   // run accepted: reload every divider with its phase
  } gateStrobe_t;

  // Field positions inside a configuration write.
  localparam int RATIO_LSB = 0;
  localparam int PHASE_LSB = 8;
  localparam int SRC_LSB   = 0;
  localparam int HOLD_LSB  = 4;

endpackage

// File: rtl/gclk_ctrl.sv
module gclk_ctrl
  import gclk_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             genEnable,
  input  logic             runValid,
  input  logic [CNT_W-1:0] runCount,
  output gateStrobe_t      strobe,
  output logic             runBusy,
  output logic             runDone,
  output logic [CNT_W-1:0] cyclesUsed
);

  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] elapsed;
  logic             busy;
  logic             accept;
  logic             budgetLeft;

  assign accept     = runValid && !busy && genEnable;
  assign budgetLeft = (remaining != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      remaining  <= '0;
      elapsed    <= '0;
      runDone    <= 1'b0;
      cyclesUsed <= '0;
    end else begin
      runDone <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        remaining <= runCount;
        elapsed   <= '0;
      end else if (busy) begin
        if (!budgetLeft) begin
          busy       <= 1'b0;
          runDone    <= 1'b1;
          cyclesUsed <= elapsed;
        end else begin
          elapsed <= elapsed + CNT_W'(1);
          if (genEnable) begin
            remaining <= remaining - CNT_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    strobe.gateOpen = busy && budgetLeft && genEnable;
    strobe.syncLoad = accept;
  end

  assign runBusy = busy;

endmodule

// File: rtl/gclk_divlane.sv
module gclk_divlane
  import gclk_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gateStrobe_t      strobe,
  input  logic             wrEn,
  input  logic [DIV_W-1:0] wrRatioM1,
  input  logic [DIV_W-1:0] wrPhase,
  output logic             tick
);

  logic [DIV_W-1:0] ratioM1;
  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] cnt;
  logic             atZero;

  assign atZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratioM1 <= '0;
      phase   <= '0;
    end else if (wrEn) begin
      ratioM1 <= wrRatioM1;
      phase   <= (wrPhase > wrRatioM1) ? wrRatioM1 : wrPhase;
    end
  end

  // Down-counter: tick on zero, reload the ratio read at the wrap.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (strobe.syncLoad) begin
      cnt <= phase;
    end else if (strobe.gateOpen) begin
      cnt <= atZero ? ratioM1 : cnt - DIV_W'(1);
    end
  end

  assign tick = strobe.gateOpen && atZero;

endmodule

// File: rtl/gclk_rstlane.sv
module gclk_rstlane #(
  parameter int NUM_OUT  = 16,
  parameter int SEL_W    = 4,
  parameter int HOLD_W   = 8,
  parameter int DEF_HOLD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSrc,
  input  logic [HOLD_W-1:0]  wrHold,
  input  logic [NUM_OUT-1:0] ticks,
  output logic               rstOut
);

  localparam logic [SEL_W:0] SRC_LIMIT = (SEL_W+1)'(NUM_OUT);

  logic [SEL_W-1:0]  src;
  logic [HOLD_W-1:0] holdCnt;
  logic              srcTick;

  always_comb begin
    srcTick = 1'b0;
    if ({1'b0, src} < SRC_LIMIT) begin
      srcTick = ticks[src];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src     <= '0;
      holdCnt <= HOLD_W'(DEF_HOLD);
    end else if (wrEn) begin
      src     <= wrSrc;
      holdCnt <= wrHold;
    end else if (holdCnt != '0 && srcTick) begin
      holdCnt <= holdCnt - HOLD_W'(1);
    end
  end

  assign rstOut = (holdCnt != '0);

endmodule

// File: rtl/gclk_datapath.sv
module gclk_datapath
  import gclk_pkg::*;
#(
  parameter int NUM_OUT  = 16,
  parameter int NUM_RST  = 4,
  parameter int DIV_W    = 7,
  parameter int SEL_W    = 4,
  parameter int HOLD_W   = 8,
  parameter int DEF_HOLD = 4,
  parameter int ADDR_W   = 5,
  parameter int CFG_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  gateStrobe_t        strobe,
  input  logic               cfgWrEn,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  output logic [NUM_OUT-1:0] clkEn,
  output logic [NUM_RST-1:0] rstOut
);

  logic unusedCfgBits;
  assign unusedCfgBits = ^cfgData;

  logic [DIV_W-1:0]  fieldRatio;
  logic [DIV_W-1:0]  fieldPhase;
  logic [SEL_W-1:0]  fieldSrc;
  logic [HOLD_W-1:0] fieldHold;

  assign fieldRatio = cfgData[RATIO_LSB +: DIV_W];
  assign fieldPhase = cfgData[PHASE_LSB +: DIV_W];
  assign fieldSrc   = cfgData[SRC_LSB +: SEL_W];
  assign fieldHold  = cfgData[HOLD_LSB +: HOLD_W];

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_div
    logic laneWr;
    assign laneWr = cfgWrEn && (cfgAddr == ADDR_W'(i));
    gclk_divlane #(.DIV_W(DIV_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (strobe),
      .wrEn      (laneWr),
      .wrRatioM1 (fieldRatio),
      .wrPhase   (fieldPhase),
      .tick      (clkEn[i])
    );
  end

  for (genvar j = 0; j < NUM_RST; j++) begin : g_rst
    logic laneWr;
    assign laneWr = cfgWrEn && (cfgAddr == ADDR_W'(NUM_OUT + j));
    gclk_rstlane #(
      .NUM_OUT  (NUM_OUT),
      .SEL_W    (SEL_W),
      .HOLD_W   (HOLD_W),
      .DEF_HOLD (DEF_HOLD)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrEn   (laneWr),
      .wrSrc  (fieldSrc),
      .wrHold (fieldHold),
      .ticks  (clkEn),
      .rstOut (rstOut[j])
    );
  end

endmodule

// File: rtl/gated_clkgen.sv
module gated_clkgen
  import gclk_pkg::*;
#(
  parameter int NUM_OUT  = 16,
  parameter int NUM_RST  = 4,
  parameter int MAX_DIV  = 128,
  parameter int HOLD_W   = 8,
  parameter int DEF_HOLD = 4,
  parameter int CNT_W    = 32,
  parameter int CFG_W    = 16,
  localparam int DIV_W   = $clog2(MAX_DIV),
  localparam int SEL_W   = $clog2(NUM_OUT),
  localparam int ADDR_W  = $clog2(NUM_OUT + NUM_RST)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               genEnable,
  input  logic               cfgWrEn,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic               runValid,
  input  logic [CNT_W-1:0]   runCount,
  output logic               runBusy,
  output logic               runDone,
  output logic [CNT_W-1:0]   cyclesUsed,
  output logic [NUM_OUT-1:0] clkEn,
  output logic [NUM_RST-1:0] rstOut
);

  gateStrobe_t strobe;

  gclk_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .genEnable  (genEnable),
    .runValid   (runValid),
    .runCount   (runCount),
    .strobe     (strobe),
    .runBusy    (runBusy),
    .runDone    (runDone),
    .cyclesUsed (cyclesUsed)
  );

  gclk_datapath #(
    .NUM_OUT  (NUM_OUT),
    .NUM_RST  (NUM_RST),
    .DIV_W    (DIV_W),
    .SEL_W    (SEL_W),
    .HOLD_W   (HOLD_W),
    .DEF_HOLD (DEF_HOLD),
    .ADDR_W   (ADDR_W),
    .CFG_W    (CFG_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .cfgWrEn (cfgWrEn),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .clkEn   (clkEn),
    .rstOut  (rstOut)
  );

endmodule

// File: rtl/gclk_checker.sv
module gclk_checker #(
  parameter int NUM_OUT = 16,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               genEnable,
  input logic               runValid,
  input logic               runBusy,
  input logic               runDone,
  input logic [CNT_W-1:0]   cyclesUsed,
  input logic [NUM_OUT-1:0] clkEn
);

  // Length of the current busy stretch, kept independently of the controller.
  logic [CNT_W-1:0] busyLen;
  always_ff @(posedge clk) begin
    if (!rst_n) busyLen <= '0;
    else        busyLen <= runBusy ? busyLen + CNT_W'(1) : '0;
  end

  p_idle_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !runBusy |-> (clkEn == '0));

  p_disabled_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !genEnable |-> (clkEn == '0));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    runDone |=> !runDone);

  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    runDone |-> !runBusy);

  p_count_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
    runDone |-> (cyclesUsed == busyLen - CNT_W'(1)));

  p_no_start_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!genEnable && !runBusy) |=> !runBusy);

  p_no_restart_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (runBusy && runValid) |=> (runBusy || runDone));

endmodule

bind gated_clkgen gclk_checker #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W)) u_gclk_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .genEnable  (genEnable),
  .runValid   (runValid),
  .runBusy    (runBusy),
  .runDone    (runDone),
  .cyclesUsed (cyclesUsed),
  .clkEn      (clkEn)
);

// File: tb/gated_clkgen_bench.sv
module gated_clkgen_bench;

  localparam int NOUT = 16;
  localparam int NRST = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        genEnable = 1'b1;
  logic        cfgWrEn = 1'b0;
  logic [4:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        runValid = 1'b0;
  logic [31:0] runCount = '0;
  logic        runBusy;
  logic        runDone;
  logic [31:0] cyclesUsed;
  logic [NOUT-1:0] clkEn;
  logic [NRST-1:0] rstOut;

  always #4 clk = ~clk;

  gated_clkgen u_gated_clkgen (
    .clk(clk), .rst_n(rst_n), .genEnable(genEnable),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .runValid(runValid), .runCount(runCount),
    .runBusy(runBusy), .runDone(runDone), .cyclesUsed(cyclesUsed),
    .clkEn(clkEn), .rstOut(rstOut)
  );

  int nChecks = 0;
  int nFails  = 0;

  // Bench-side model of the configuration.
  int ratioOf[NOUT];
  int phaseOf[NOUT];
  int srcOf[NRST];
  int holdOf[NRST];

  // Observations, collected at the falling edge.
  int ticks[NOUT];
  int firstIdx[NOUT];
  int hiTicks[NRST];
  int pauses;
  int curN;
  int doneSeen;
  int idleTicks;
  longint lastUsed;

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expTicks(int n, int r, int p);
    if (n > p) return (n - 1 - p) / r + 1;
    return 0;
  endfunction

  function automatic int expFirst(int n, int p);
    return (n > p) ? p : -1;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      int idx;
      idx = ticks[0];
      if (!runBusy && clkEn != '0) idleTicks++;
      if (runBusy && !genEnable && ticks[0] < curN) pauses++;
      for (int j = 0; j < NRST; j++)
        if (rstOut[j] && clkEn[srcOf[j]]) hiTicks[j]++;
      for (int i = 0; i < NOUT; i++) begin
        if (clkEn[i]) begin
          if (firstIdx[i] < 0) firstIdx[i] = idx;
          ticks[i]++;
        end
      end
      if (runDone) begin
        doneSeen++;
        lastUsed = cyclesUsed;
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cfgWrite(input int addr, input logic [15:0] d);
    cfgWrEn = 1'b1;
    cfgAddr = 5'(addr);
    cfgData = d;
    step();
    cfgWrEn = 1'b0;
  endtask

  task automatic setOut(input int i, input int r, input int p);
    logic [15:0] d;
    d = '0;
    d[6:0]  = 7'(r - 1);
    d[14:8] = 7'(p);
    ratioOf[i] = r;
    phaseOf[i] = imin(p, r - 1);
    cfgWrite(i, d);
  endtask

  task automatic setRst(input int j, input int src, input int hold);
    logic [15:0] d;
    d = '0;
    d[3:0]  = 4'(src);
    d[11:4] = 8'(hold);
    srcOf[j]  = src;
    holdOf[j] = hold;
    cfgWrite(16 + j, d);
    hiTicks[j] = 0;
  endtask

  task automatic startRun(input int n);
    for (int i = 0; i < NOUT; i++) begin
      ticks[i] = 0;
      firstIdx[i] = -1;
    end
    pauses = 0;
    doneSeen = 0;
    curN = n;
    genEnable = 1'b1;
    runValid = 1'b1;
    runCount = 32'(n);
    step();
    runValid = 1'b0;
  endtask

  task automatic waitDone(input int pausePct);
    int guard;
    guard = 0;
    while (doneSeen == 0 && guard < 20000) begin
      genEnable = (32'($urandom % 100) >= 32'(pausePct));
      step();
      guard++;
    end
    genEnable = 1'b1;
    chk("R8 completion seen", (doneSeen > 0) ? 1 : 0, 1);
  endtask

  task automatic checkRun(input int n);
    chk("R3 open cycles", ticks[0], n);
    chk("R7 reported count", lastUsed, n + pauses);
    chk("R8 single completion", doneSeen, 1);
    chk("R8 busy low after run", runBusy, 0);
    for (int i = 1; i < NOUT; i++) begin
      chk($sformatf("R4 tick count out%0d", i), ticks[i],
          expTicks(n, ratioOf[i], phaseOf[i]));
      chk($sformatf("R11 first tick out%0d", i), firstIdx[i],
          expFirst(n, phaseOf[i]));
    end
    for (int j = 0; j < NRST; j++) begin
      chk($sformatf("R10 hold ticks lane%0d", j), hiTicks[j],
          imin(holdOf[j], ticks[srcOf[j]]));
      chk($sformatf("R10 reset level lane%0d", j), rstOut[j],
          (ticks[srcOf[j]] < holdOf[j]) ? 1 : 0);
    end
  endtask

  initial begin
    int r;
    int p;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NOUT; i++) begin
      ratioOf[i] = 1;
      phaseOf[i] = 0;
      ticks[i] = 0;
      firstIdx[i] = -1;
    end
    for (int j = 0; j < NRST; j++) begin
      srcOf[j] = 0;
      holdOf[j] = 4;
      hiTicks[j] = 0;
    end
    pauses = 0; curN = 0; doneSeen = 0; idleTicks = 0; lastUsed = 0;

    repeat (3) step();
    rst_n = 1'b1;
    step();
    @(negedge clk);
    chk("R1 enables low", clkEn, 0);
    chk("R1 idle", runBusy, 0);
    chk("R1 no completion", runDone, 0);
    chk("R1 count zero", cyclesUsed, 0);
    chk("R1 resets asserted", rstOut, 4'hF);
    step();

    // Default reset lanes release after 4 ticks of output 0.
    startRun(10);
    waitDone(0);
    checkRun(10);

    // Zero budget.
    startRun(0);
    waitDone(0);
    chk("R8 zero budget count", lastUsed, 0);
    chk("R8 zero budget ticks", ticks[0], 0);

    // Phase clamp and realignment across runs.
    setOut(3, 4, 1);
    setOut(4, 4, 9);
    for (int k = 0; k < 2; k++) begin
      startRun(5);
      waitDone(0);
      checkRun(5);
      chk("R5 clamped phase first tick", firstIdx[4], 3);
      chk("R11 realigned phase", firstIdx[3], 1);
    end

    // Ratio change in the middle of a run.
    setOut(2, 4, 0);
    startRun(20);
    step();
    begin
      logic [15:0] d;
      d = '0;
      d[6:0] = 7'd1;
      cfgWrite(2, d);
    end
    waitDone(0);
    chk("R6 ticks after late ratio change", ticks[2], 9);
    chk("R3 open cycles, ratio change run", ticks[0], 20);
    ratioOf[2] = 2;
    phaseOf[2] = 0;

    // Request ignored while busy.
    startRun(30);
    repeat (4) step();
    runValid = 1'b1;
    runCount = 32'd5;
    step();
    runValid = 1'b0;
    waitDone(0);
    repeat (10) step();
    chk("R9 busy request ignored, count", lastUsed, 30);
    chk("R9 busy request ignored, completions", doneSeen, 1);
    chk("R9 busy request ignored, open cycles", ticks[0], 30);

    // Request ignored while disabled.
    doneSeen = 0;
    genEnable = 1'b0;
    runValid = 1'b1;
    runCount = 32'd8;
    step();
    runValid = 1'b0;
    repeat (5) step();
    @(negedge clk);
    chk("R9 disabled request ignored, busy", runBusy, 0);
    chk("R9 disabled request ignored, completions", doneSeen, 0);
    step();
    genEnable = 1'b1;

    // Random runs with pauses.
    for (int run = 0; run < 25; run++) begin
      for (int i = 1; i < NOUT; i++) begin
        r = 1 + int'($urandom % 128);
        if (($urandom % 8) == 0) p = int'($urandom % 128);
        else p = int'($urandom % r);
        setOut(i, r, p);
      end
      for (int j = 0; j < NRST; j++)
        setRst(j, int'($urandom % NOUT), int'($urandom % 21));
      startRun(int'($urandom % 300));
      waitDone(15);
      checkRun(curN);
    end

    chk("R2 no ticks outside runs", idleTicks, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule